// File: doc/BRIEF.md
# Dual-Port Memory with Collision Arbitration and Semaphores

This block is a synchronous model of a true dual-ported memory. A left port and a right port each carry an address, write data, read data with a valid flag, two chip enables of opposite polarity, a read/write select and an active-low output enable. Both ports may read or write any word in the same cycle, including the same word. When both ports reach the same word, a fixed left-wins arbiter raises the right port's busy flag and drops the right port's write.

A mode input chooses where busy comes from. In master mode the on-chip arbiter decides and drives the busy outputs. In slave mode the busy outputs stay low and each port's busy input blocks that port's write. Several devices can then be placed side by side for a wider word, with one master deciding for all of them.

A separate active-low semaphore select on each port reaches a bank of eight one-owner token latches instead of the array. Software on the two sides uses these latches to pass tokens.

Top module: `twin_port_ram`

## Requirements
- R1: A port reaches the array only when its low-active enable is 0 and its high-active enable is 1 with the semaphore select high; any other enable pattern writes nothing and produces no read (rvalid stays 0).
- R2: The two ports operate independently and concurrently on different words; read data for an access at clock edge k is presented with rvalid=1 after edge k and is held until edge k+1.
- R3: rdata and rvalid are nonzero only after a read access (rw=1) made with output enable low; a read with output enable high, or any write, leaves rvalid=0 and rdata=0.
- R4: In master mode (master=1), when both ports access the same word in the same cycle, r_busy_o is 1 after that edge, and l_busy_o stays 0.
- R5: In master mode, when both ports write the same word in one cycle, the left port's data is stored and the right port's write is dropped.
- R6: In slave mode (master=0), both busy outputs stay 0, a port whose busy input is 1 does not write, and a port whose busy input is 0 writes normally.
- R7: A semaphore access (sem_n=0) selects latch addr[2:0]. Writing wdata[0]=0 claims the latch. Reading it returns all zeros to the port that owns it and all ones to any other port.
- R8: A claim of a latch that the other port owns is refused, and the latch keeps its owner.
- R9: Writing wdata[0]=1 releases a latch only for its owner. The same write from the non-owner has no effect. After a release, the other port can claim the latch.
- R10: When both ports claim the same free latch in one cycle, the left port gets it.
- R11: Semaphore accesses never change the array contents.
- R12: When one port writes a word that the other port reads in the same cycle, the reader receives the word's value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master | input | 1 | 1: arbiter drives busy; 0: busy taken from inputs |
| l_cs_n | input | 1 | Left low-active enable |
| l_cs | input | 1 | Left high-active enable |
| l_rw | input | 1 | Left 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, low-active |
| l_sem_n | input | 1 | Left semaphore select, low-active |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_i | input | 1 | Left write block (slave mode) |
| l_busy_o | output | 1 | Left busy flag (master mode) |
| r_cs_n | input | 1 | Right low-active enable |
| r_cs | input | 1 | Right high-active enable |
| r_rw | input | 1 | Right 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, low-active |
| r_sem_n | input | 1 | Right semaphore select, low-active |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_i | input | 1 | Right write block (slave mode) |
| r_busy_o | output | 1 | Right busy flag (master mode) |

## Verification
The hardest situations to reach are the ones where the two ports act on the same target in the same cycle. These cover two writes to one word, a write racing a read, two claims on one free latch, and a release racing a foreign claim. The bench drives both ports from a single task step, so every such pair lands on the same clock edge. It then reads the outcome back through later ordinary reads, and through semaphore reads from both sides, rather than trusting the busy flag alone.

// File: rtl/twin_ram_pkg.sv
package twin_ram_pkg;
  localparam int SEM_COUNT = 8;
  localparam int SEM_IDX_W = $clog2(SEM_COUNT);
  localparam int PORTS     = 2;
  localparam int LEFT      = 0;
  localparam int RIGHT     = 1;

  function automatic logic port_enabled(input logic cs_n, input logic cs);
    return ~cs_n & cs;
  endfunction
endpackage

// File: rtl/tpr_array.sv
module tpr_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // read-first on both ports; at most one writer per word per cycle
  always_ff @(posedge clk) begin
    if (a_en) a_dout <= cells[a_addr];
    if (b_en) b_dout <= cells[b_addr];
    if (a_we) cells[a_addr] <= a_din;
    if (b_we) cells[b_addr] <= b_din;
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
    !(a_we && b_we && a_addr == b_addr)); // R5
endmodule

// File: rtl/tpr_sem.sv
module tpr_sem
  import twin_ram_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 l_acc,
  input  logic                 l_wr,
  input  logic                 l_bit,
  input  logic [SEM_IDX_W-1:0] l_idx,
  input  logic                 r_acc,
  input  logic                 r_wr,
  input  logic                 r_bit,
  input  logic [SEM_IDX_W-1:0] r_idx,
  output logic                 l_own_q,
  output logic                 r_own_q
);
  logic [SEM_COUNT-1:0] own_l, own_r, nxt_l, nxt_r;
  logic l_claim, r_claim;

  assign l_claim = l_acc & l_wr & ~l_bit;
  assign r_claim = r_acc & r_wr & ~r_bit;

  // decisions use the state from before this edge; left wins ties
  always_comb begin
    nxt_l = own_l;
    nxt_r = own_r;
    if (l_acc && l_wr) begin
      if (l_bit)               nxt_l[l_idx] = 1'b0;
      else if (!own_r[l_idx])  nxt_l[l_idx] = 1'b1;
    end
    if (r_acc && r_wr) begin
      if (r_bit)
        nxt_r[r_idx] = 1'b0;
      else if (!own_l[r_idx] && !(l_claim && l_idx == r_idx))
        nxt_r[r_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_l   <= '0;
      own_r   <= '0;
      l_own_q <= 1'b0;
      r_own_q <= 1'b0;
    end else begin
      own_l   <= nxt_l;
      own_r   <= nxt_r;
      l_own_q <= own_l[l_idx];
      r_own_q <= own_r[r_idx];
    end
  end

  AST_SEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (own_l & own_r) == '0); // R8
  AST_SEM_QUIET: assert property (@(posedge clk) disable iff (rst)
    !l_acc && !r_acc |=> $stable(own_l) && $stable(own_r)); // R9
  AST_SEM_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
    l_claim && r_claim && l_idx == r_idx && !own_l[l_idx] && !own_r[l_idx]
    |=> own_l[$past(l_idx)] && !own_r[$past(l_idx)]); // R10
endmodule

// File: rtl/tpr_rdout.sv
module tpr_rdout #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              from_sem,
  input  logic [DATA_W-1:0] mem_q,
  input  logic              own_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic sel_sem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid    <= 1'b0;
      sel_sem_q <= 1'b0;
    end else begin
      rvalid    <= fire;
      sel_sem_q <= from_sem;
    end
  end

  always_comb begin
    if (!rvalid)        rdata = '0;
    else if (sel_sem_q) rdata = {DATA_W{~own_q}};
    else                rdata = mem_q;
  end
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import twin_ram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master,
  input  logic              l_cs_n,
  input  logic              l_cs,
  input  logic              l_rw,
  input  logic              l_oe_n,
  input  logic              l_sem_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  input  logic              r_cs_n,
  input  logic              r_cs,
  input  logic              r_rw,
  input  logic              r_oe_n,
  input  logic              r_sem_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  input  logic              r_busy_i,
  output logic              r_busy_o
);
  logic [PORTS-1:0] en, mem_acc, sem_acc, fire, block, we, lose, busy_q, own_q, ext_busy;
  logic [PORTS-1:0] rw, oe_n, sem_n;
  logic [DATA_W-1:0] mem_q [PORTS];
  logic [DATA_W-1:0] rd_v  [PORTS];
  logic              collide;

  assign en[LEFT]        = port_enabled(l_cs_n, l_cs);
  assign en[RIGHT]       = port_enabled(r_cs_n, r_cs);
  assign rw              = {r_rw, l_rw};
  assign oe_n            = {r_oe_n, l_oe_n};
  assign sem_n           = {r_sem_n, l_sem_n};
  assign ext_busy        = {r_busy_i, l_busy_i};

  assign collide = mem_acc[LEFT] & mem_acc[RIGHT] & (l_addr == r_addr);

  // fixed priority: the left port never loses
  assign lose[LEFT]  = 1'b0;
  assign lose[RIGHT] = collide;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign sem_acc[p] = ~sem_n[p];
    assign mem_acc[p] = en[p] & sem_n[p];
    assign fire[p]    = (mem_acc[p] | sem_acc[p]) & rw[p] & ~oe_n[p];
    assign block[p]   = master ? lose[p] : ext_busy[p];
    assign we[p]      = mem_acc[p] & ~rw[p] & ~block[p];

    always_ff @(posedge clk) begin
      if (rst) busy_q[p] <= 1'b0;
      else     busy_q[p] <= master & lose[p];
    end

    tpr_rdout #(.DATA_W(DATA_W)) u_out (
      .clk     (clk),
      .rst     (rst),
      .fire    (fire[p]),
      .from_sem(sem_acc[p]),
      .mem_q   (mem_q[p]),
      .own_q   (own_q[p]),
      .rdata   (rd_v[p]),
      .rvalid  ()
    );
  end

  // valid flags registered here so the port outputs come straight from flops
  logic [PORTS-1:0] valid_q;
  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= fire;
  end

  assign l_rdata  = rd_v[LEFT];
  assign r_rdata  = rd_v[RIGHT];
  assign l_rvalid = valid_q[LEFT];
  assign r_rvalid = valid_q[RIGHT];
  assign l_busy_o = busy_q[LEFT];
  assign r_busy_o = busy_q[RIGHT];

  tpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .rst   (rst),
    .a_en  (mem_acc[LEFT]),
    .a_we  (we[LEFT]),
    .a_addr(l_addr),
    .a_din (l_wdata),
    .a_dout(mem_q[LEFT]),
    .b_en  (mem_acc[RIGHT]),
    .b_we  (we[RIGHT]),
    .b_addr(r_addr),
    .b_din (r_wdata),
    .b_dout(mem_q[RIGHT])
  );

  tpr_sem u_sem (
    .clk    (clk),
    .rst    (rst),
    .l_acc  (sem_acc[LEFT]),
    .l_wr   (~l_rw),
    .l_bit  (l_wdata[0]),
    .l_idx  (l_addr[SEM_IDX_W-1:0]),
    .r_acc  (sem_acc[RIGHT]),
    .r_wr   (~r_rw),
    .r_bit  (r_wdata[0]),
    .r_idx  (r_addr[SEM_IDX_W-1:0]),
    .l_own_q(own_q[LEFT]),
    .r_own_q(own_q[RIGHT])
  );

  AST_RBUSY_ON_SAME_WORD: assert property (@(posedge clk) disable iff (rst)
    master && !l_cs_n && l_cs && !r_cs_n && r_cs && l_sem_n && r_sem_n && l_addr == r_addr
    |=> r_busy_o && !l_busy_o); // R4
  AST_SLAVE_BUSY_LOW: assert property (@(posedge clk) disable iff (rst)
    !master |=> !l_busy_o && !r_busy_o); // R6
  AST_VALID_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    !(l_rw && !l_oe_n) |=> !l_rvalid); // R3
  AST_RDATA_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !r_rvalid |-> r_rdata == '0); // R3
endmodule

// File: tb/sim_twin_port_ram.sv
module sim_twin_port_ram;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, master;
  logic l_cs_n, l_cs, l_rw, l_oe_n, l_sem_n, l_busy_i, l_busy_o, l_rvalid;
  logic r_cs_n, r_cs, r_rw, r_oe_n, r_sem_n, r_busy_i, r_busy_o, r_rvalid;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  twin_port_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .master(master),
    .l_cs_n(l_cs_n), .l_cs(l_cs), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_sem_n(l_sem_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .l_busy_i(l_busy_i), .l_busy_o(l_busy_o),
    .r_cs_n(r_cs_n), .r_cs(r_cs), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_sem_n(r_sem_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid),
    .r_busy_i(r_busy_i), .r_busy_o(r_busy_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic lset(input logic cs_n, cs, rw, oe_n, sem_n,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_cs_n = cs_n; l_cs = cs; l_rw = rw; l_oe_n = oe_n; l_sem_n = sem_n;
    l_addr = a; l_wdata = d;
  endtask

  task automatic rset(input logic cs_n, cs, rw, oe_n, sem_n,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_cs_n = cs_n; r_cs = cs; r_rw = rw; r_oe_n = oe_n; r_sem_n = sem_n;
    r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    lset(1, 0, 1, 1, 1, '0, '0);
    rset(1, 0, 1, 1, 1, '0, '0);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic lwr(input logic [AW-1:0] a, input logic [DW-1:0] d); lset(0, 1, 0, 1, 1, a, d); endtask
  task automatic rwr(input logic [AW-1:0] a, input logic [DW-1:0] d); rset(0, 1, 0, 1, 1, a, d); endtask
  task automatic lrd(input logic [AW-1:0] a); lset(0, 1, 1, 0, 1, a, '0); endtask
  task automatic rrd(input logic [AW-1:0] a); rset(0, 1, 1, 0, 1, a, '0); endtask
  task automatic lsw(input logic [AW-1:0] i, input logic b); lset(1, 0, 0, 1, 0, i, {{(DW-1){1'b0}}, b}); endtask
  task automatic rsw(input logic [AW-1:0] i, input logic b); rset(1, 0, 0, 1, 0, i, {{(DW-1){1'b0}}, b}); endtask
  task automatic lsr(input logic [AW-1:0] i); lset(1, 0, 1, 0, 0, i, '0); endtask
  task automatic rsr(input logic [AW-1:0] i); rset(1, 0, 1, 0, 0, i, '0); endtask

  task automatic t_reset();
    chk("R3 reset l_rvalid", l_rvalid, 0);
    chk("R3 reset l_rdata", l_rdata, 0);
    chk("R3 reset r_rvalid", r_rvalid, 0);
    chk("R4 reset r_busy_o", r_busy_o, 0);
  endtask

  task automatic t_enable();
    idle(); lwr(5, 8'h11); step();
    idle(); lset(1, 1, 0, 1, 1, 5, 8'hAA); step();
    idle(); lset(0, 0, 0, 1, 1, 5, 8'hBB); step();
    idle(); lset(1, 0, 1, 0, 1, 5, '0); step();
    chk("R1 disabled read rvalid", l_rvalid, 0);
    idle(); lrd(5); step();
    chk("R1 enabled read rvalid", l_rvalid, 1);
    chk("R1 disabled writes ignored", l_rdata, 8'h11);
  endtask

  task automatic t_concurrent();
    idle(); lwr(1, 8'hA0); rwr(2, 8'hB0); step();
    idle(); lrd(2); rrd(1); step();
    chk("R2 left reads right's word", l_rdata, 8'hB0);
    chk("R2 right reads left's word", r_rdata, 8'hA0);
    chk("R2 right rvalid", r_rvalid, 1);
    idle(); step();
    chk("R2 rvalid drops after one cycle", l_rvalid, 0);
  endtask

  task automatic t_oe();
    idle(); lset(0, 1, 1, 1, 1, 1, '0); step();
    chk("R3 oe high rvalid", l_rvalid, 0);
    chk("R3 oe high rdata", l_rdata, 0);
    idle(); rset(0, 1, 0, 0, 1, 7, 8'h07); step();
    chk("R3 write with oe low rvalid", r_rvalid, 0);
    chk("R3 write with oe low rdata", r_rdata, 0);
  endtask

  task automatic t_collision();
    idle(); lwr(9, 8'h55); rwr(9, 8'h66); step();
    chk("R4 right busy on same word", r_busy_o, 1);
    chk("R4 left never busy", l_busy_o, 0);
    idle(); step();
    chk("R4 right busy clears", r_busy_o, 0);
    idle(); rrd(9); step();
    chk("R5 left data kept", r_rdata, 8'h55);
  endtask

  task automatic t_read_during_write();
    idle(); lwr(9, 8'h77); rrd(9); step();
    chk("R12 reader sees old value", r_rdata, 8'h55);
    chk("R12 reader valid", r_rvalid, 1);
    idle(); lrd(9); step();
    chk("R12 write landed", l_rdata, 8'h77);
  endtask

  task automatic t_slave();
    idle(); lwr(20, 8'h12); rwr(21, 8'h34); step();
    master = 1'b0;
    idle(); r_busy_i = 1'b1; rwr(21, 8'h99); lwr(22, 8'h56); step();
    idle(); r_busy_i = 1'b0; l_busy_i = 1'b1; lwr(20, 8'hEE); rwr(23, 8'h78); step();
    l_busy_i = 1'b0;
    idle(); lrd(21); rrd(20); step();
    chk("R6 right write blocked", l_rdata, 8'h34);
    chk("R6 left write blocked", r_rdata, 8'h12);
    idle(); lrd(22); rrd(22); step();
    chk("R6 unblocked left write", l_rdata, 8'h56);
    chk("R6 same-word read right", r_rdata, 8'h56);
    chk("R6 slave busy right low", r_busy_o, 0);
    chk("R6 slave busy left low", l_busy_o, 0);
    idle(); rrd(23); step();
    chk("R6 unblocked right write", r_rdata, 8'h78);
    master = 1'b1;
  endtask

  task automatic t_sem();
    idle(); lwr(3, 8'h3C); step();
    idle(); lsw(3, 0); step();
    idle(); lsr(3); rsr(3); step();
    chk("R7 owner reads zeros", l_rdata, 8'h00);
    chk("R7 other reads ones", r_rdata, 8'hFF);
    idle(); rsw(3, 0); step();
    idle(); lsr(3); rsr(3); step();
    chk("R8 foreign claim refused right", r_rdata, 8'hFF);
    chk("R8 owner kept", l_rdata, 8'h00);
    idle(); rsw(3, 1); step();
    idle(); lsr(3); step();
    chk("R9 non-owner release ignored", l_rdata, 8'h00);
    idle(); lsw(3, 1); step();
    idle(); rsw(3, 0); step();
    idle(); lsr(3); rsr(3); step();
    chk("R9 right owns after release", r_rdata, 8'h00);
    chk("R9 left no longer owns", l_rdata, 8'hFF);
    idle(); rsw(3, 1); step();
    idle(); lsw(5, 0); rsw(5, 0); step();
    idle(); lsr(5); rsr(5); step();
    chk("R10 tie to left", l_rdata, 8'h00);
    chk("R10 right loses tie", r_rdata, 8'hFF);
    idle(); lrd(3); step();
    chk("R11 array word untouched", l_rdata, 8'h3C);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; master = 1'b1; l_busy_i = 1'b0; r_busy_i = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_concurrent();
    t_oe();
    t_collision();
    t_read_during_write();
    t_slave();
    t_sem();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule